// File: doc/BRIEF.md
# PHY DLL Lock and Freeze Controller

This block brings a memory PHY's delay-locked loop out of reset and hands the PHY a final delay control word. When a start pulse is accepted, it drives three control words in turn: the parameter word with the DLL off and idle, the same word with the DLL enabled, and then with the DLL running. It then polls the PHY status word until all three lock flags read high. It extracts the measured 8-bit lock value and moves it into the force field of the control word.

Two modes are available. In tracking mode the DLL stays enabled and running with the forced value applied. This is the setting for reliable operation across process, voltage and temperature drift. In fixed mode, one cycle later, the block clears the DLL-enable bit so that the forced delay is frozen. This is meant only for low clock frequencies. A programmable timeout flags a DLL that never locks. The status word is resynchronised through two flops because the PHY may run on another clock.

All pins are plain control and status signals. There is no data stream and so no valid/ready handshake: a start pulse is either accepted (block idle) or dropped (block busy).

Top module: `dll_lock_ctrl`

## Requirements
- R1: After reset, phy_ctrl_o is 0x00000000 and done_o, locked_o and tmo_err_o are low.
- R2: After an accepted start, phy_ctrl_o reads 0x00101000 in the first cycle, 0x00101002 (bit 1 = DLL enable) in the second and 0x00101003 (bit 0 = DLL start) in the third.
- R3: Lock is recognised only when status bits [2:0] are all 1. Any other value of those bits keeps the block waiting with locked_o low.
- R4: On lock, the lock value is status bits [13:6], placed at control bits [25:18]. The tracking-mode final word is (value << 18) | 0x00101003, and locked_o goes high.
- R5: In fixed mode (fixed_mode_i = 1 at start), the cycle after the tracking word has been driven, the word becomes (value << 18) | 0x00101001, with the DLL-enable bit cleared.
- R6: done_o is high for exactly one cycle: the first cycle in which the final word of the selected mode is on phy_ctrl_o.
- R7: A start pulse while busy is ignored, and so is any change of fixed_mode_i. The mode is taken at the accepted start.
- R8: If lock is not seen within tmo_limit_i + 1 waiting cycles, tmo_err_o rises, done_o stays low and the block returns to idle. The next accepted start clears tmo_err_o and locked_o.
- R9: The status passes through a two-flop synchroniser. A lock that appears just before clock edge n changes phy_ctrl_o at edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| fixed_mode_i | input | 1 | 1 = freeze the delay with the DLL off, 0 = tracking |
| tmo_limit_i | input | TMO_W | Lock timeout, in waiting cycles |
| phy_status_i | input | STAT_W | PHY status word (asynchronous) |
| phy_ctrl_o | output | 32 | Control word to the PHY |
| done_o | output | 1 | One-cycle completion pulse |
| locked_o | output | 1 | Lock captured in the current run |
| tmo_err_o | output | 1 | Lock timeout error |

## Verification
On every cycle, the assertions check the order of the three bring-up words, the single-cycle width of done and its link to locked, a cleared DLL-enable bit when a frozen run completes, the fact that partial lock flags never set locked, the fixed mode while busy, and the timer holding at its limit. Only the bench scenarios can show the exact words built from a chosen lock value under noisy status bits, the two-cycle synchroniser delay, dropped start pulses in mid-run, and the timeout followed by a clean restart.

// File: rtl/dll_pkg.sv
package dll_pkg;
  localparam int CTRL_W    = 32;
  localparam int FLAG_W    = 3;
  localparam int LOCK_LSB  = 6;
  localparam int LOCK_W    = 8;
  localparam int FORCE_LSB = 18;
  localparam int ON_BIT    = 1;
  localparam int RUN_BIT   = 0;

  localparam logic [CTRL_W-1:0] BASE_WORD = 32'h0010_1000;
  localparam logic [CTRL_W-1:0] ON_MASK   = 32'h0000_0002;
  localparam logic [CTRL_W-1:0] RUN_MASK  = 32'h0000_0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLL_ON,
    ST_RUN,
    ST_WAIT,
    ST_FREEZE
  } dll_state_e;

  function automatic logic [CTRL_W-1:0] force_word(input logic [LOCK_W-1:0] val);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[FORCE_LSB +: LOCK_W] = val;
    return w | BASE_WORD | ON_MASK | RUN_MASK;
  endfunction
endpackage

// File: rtl/dll_status_sync.sv
module dll_status_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && cnt_q != limit_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = en_i && (cnt_q == limit_i);

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && cnt_q == limit_i) |=> (cnt_q == $past(cnt_q))); // R8
endmodule

// File: rtl/dll_word_fsm.sv
module dll_word_fsm
  import dll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fixed_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [LOCK_W-1:0] lock_val_i,
  input  logic              expired_i,
  output logic              tmr_clr_o,
  output logic              tmr_en_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o,
  output logic              locked_o,
  output logic              err_o
);
  dll_state_e        state_q;
  logic              fixed_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              done_q, locked_q, err_q;
  logic              lock_seen;

  assign lock_seen = &flags_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fixed_q  <= 1'b0;
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ctrl_q   <= BASE_WORD;
            fixed_q  <= fixed_i;
            locked_q <= 1'b0;
            err_q    <= 1'b0;
            state_q  <= ST_DLL_ON;
          end
        end
        ST_DLL_ON: begin
          ctrl_q  <= BASE_WORD | ON_MASK;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          ctrl_q  <= BASE_WORD | ON_MASK | RUN_MASK;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lock_seen) begin
            ctrl_q   <= force_word(lock_val_i);
            locked_q <= 1'b1;
            if (fixed_q) begin
              state_q <= ST_FREEZE;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else if (expired_i) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FREEZE: begin
          ctrl_q  <= ctrl_q & ~ON_MASK;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tmr_clr_o = (state_q != ST_WAIT);
  assign tmr_en_o  = (state_q == ST_WAIT);
  assign ctrl_o    = ctrl_q;
  assign done_o    = done_q;
  assign locked_o  = locked_q;
  assign err_o     = err_q;

  AST_SEQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == BASE_WORD) |=> (ctrl_q == (BASE_WORD | ON_MASK))); // R2
  AST_SEQ_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == (BASE_WORD | ON_MASK)) |=> (ctrl_q == (BASE_WORD | ON_MASK | RUN_MASK))); // R2
  AST_PARTIAL_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !lock_seen) |=> !locked_q); // R3
  AST_DONE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> locked_q); // R4
  AST_FROZEN_DLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fixed_q) |-> !ctrl_q[ON_BIT]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(fixed_q)); // R7
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !done_q); // R8
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fixed_mode_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic [STAT_W-1:0] phy_status_i,
  output logic [CTRL_W-1:0] phy_ctrl_o,
  output logic              done_o,
  output logic              locked_o,
  output logic              tmo_err_o
);
  localparam int SYNC_W = LOCK_W + FLAG_W;

  logic [SYNC_W-1:0] stat_raw, stat_sync;
  logic              tmr_clr, tmr_en, expired;

  assign stat_raw = {phy_status_i[LOCK_LSB +: LOCK_W], phy_status_i[FLAG_W-1:0]};

  dll_status_sync #(.W(SYNC_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stat_raw),
    .sync_o  (stat_sync)
  );

  dll_lock_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .limit_i   (tmo_limit_i),
    .expired_o (expired)
  );

  dll_word_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .fixed_i    (fixed_mode_i),
    .flags_i    (stat_sync[FLAG_W-1:0]),
    .lock_val_i (stat_sync[FLAG_W +: LOCK_W]),
    .expired_i  (expired),
    .tmr_clr_o  (tmr_clr),
    .tmr_en_o   (tmr_en),
    .ctrl_o     (phy_ctrl_o),
    .done_o     (done_o),
    .locked_o   (locked_o),
    .err_o      (tmo_err_o)
  );
endmodule

// File: tb/dll_lock_ctrl_tb.sv
module dll_lock_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        fixed_mode_i = 1'b0;
  logic [15:0] tmo_limit_i = 16'd1000;
  logic [31:0] phy_status_i = 32'h0;
  logic [31:0] phy_ctrl_o;
  logic        done_o, locked_o, tmo_err_o;

  int n_run = 0;
  int n_fail = 0;
  int n_done = 0;

  localparam logic [31:0] NOISE = 32'hAAA8_0028; // bits outside [13:6] and [2:0]

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n && done_o) n_done++;

  dll_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fixed_mode_i(fixed_mode_i),
    .tmo_limit_i(tmo_limit_i), .phy_status_i(phy_status_i),
    .phy_ctrl_o(phy_ctrl_o), .done_o(done_o), .locked_o(locked_o), .tmo_err_o(tmo_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fword(input logic [7:0] v, input bit on);
    logic [31:0] w;
    w = ({24'h0, v} << 18) | 32'h0010_1001;
    if (on) w = w | 32'h2;
    return w;
  endfunction

  function automatic logic [31:0] stat(input logic [7:0] v, input logic [2:0] f);
    return NOISE | ({24'h0, v} << 6) | {29'h0, f};
  endfunction

  // Pulse start, then check the three bring-up words (R2)
  task automatic kick(input bit mode);
    @(negedge clk);
    phy_status_i = NOISE;
    start_i = 1'b1; fixed_mode_i = mode;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 word1", phy_ctrl_o, 32'h0010_1000);
    @(negedge clk);
    chk("R2 word2", phy_ctrl_o, 32'h0010_1002);
    @(negedge clk);
    chk("R2 word3", phy_ctrl_o, 32'h0010_1003);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", phy_ctrl_o, 32'h0);
    chk("R1 flags", {29'h0, done_o, locked_o, tmo_err_o}, 32'h0);
  endtask

  task automatic t_track(input logic [7:0] v);
    int d0;
    kick(1'b0);
    d0 = n_done;
    phy_status_i = stat(v, 3'b111);
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet", phy_ctrl_o, 32'h0010_1003);
    @(negedge clk);
    chk("R4 track word", phy_ctrl_o, fword(v, 1'b1));
    chk("R4 locked", {31'h0, locked_o}, 32'h1);
    chk("R6 done high", {31'h0, done_o}, 32'h1);
    @(negedge clk);
    chk("R6 done one cycle", n_done - d0, 1);
  endtask

  task automatic t_fixed(input logic [7:0] v);
    kick(1'b1);
    phy_status_i = stat(v, 3'b111);
    repeat (3) @(negedge clk);
    chk("R5 interim word", phy_ctrl_o, fword(v, 1'b1));
    chk("R6 no early done", {31'h0, done_o}, 32'h0);
    @(negedge clk);
    chk("R5 frozen word", phy_ctrl_o, fword(v, 1'b0));
    chk("R6 done fixed", {31'h0, done_o}, 32'h1);
  endtask

  task automatic t_partial;
    kick(1'b0);
    phy_status_i = stat(8'h5A, 3'b011);
    repeat (5) @(negedge clk);
    phy_status_i = stat(8'h5A, 3'b110);
    repeat (5) @(negedge clk);
    chk("R3 partial ctrl", phy_ctrl_o, 32'h0010_1003);
    chk("R3 partial locked", {31'h0, locked_o}, 32'h0);
    phy_status_i = stat(8'h5A, 3'b111);
    repeat (3) @(negedge clk);
    chk("R3 full flags lock", phy_ctrl_o, fword(8'h5A, 1'b1));
  endtask

  task automatic t_busy;
    int d0;
    kick(1'b0);
    d0 = n_done;
    start_i = 1'b1; fixed_mode_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R7 no restart", phy_ctrl_o, 32'h0010_1003);
    phy_status_i = stat(8'hC3, 3'b111);
    repeat (5) @(negedge clk);
    chk("R7 mode kept", phy_ctrl_o, fword(8'hC3, 1'b1));
    chk("R7 one done", n_done - d0, 1);
    fixed_mode_i = 1'b0;
  endtask

  task automatic t_timeout;
    int d0;
    tmo_limit_i = 16'd8;
    kick(1'b0);
    d0 = n_done;
    repeat (30) @(negedge clk);
    chk("R8 err", {31'h0, tmo_err_o}, 32'h1);
    chk("R8 no done", n_done - d0, 0);
    chk("R8 ctrl kept", phy_ctrl_o, 32'h0010_1003);
    phy_status_i = stat(8'h11, 3'b111);
    repeat (4) @(negedge clk);
    chk("R8 idle ignores lock", {31'h0, locked_o}, 32'h0);
    tmo_limit_i = 16'd1000;
    @(negedge clk);
    start_i = 1'b1; fixed_mode_i = 1'b0; phy_status_i = NOISE;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 err cleared", {31'h0, tmo_err_o}, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_track(8'hA5);
    chk("R4 locked stays", {31'h0, locked_o}, 32'h1);
    t_fixed(8'h3C);
    t_track(8'hFF);
    t_partial();
    t_busy();
    t_timeout();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule